// File: doc/BRIEF.md
# Video Output Stream Formatter

This block turns a stream of scaled pixel bytes into an 8-bit output stream. Each incoming beat carries one pixel byte together with its field identifier, its horizontal-active and vertical-active flags, and markers for the first and last pixel of a line. Around every line the formatter inserts embedded timing reference sequences. Each sequence is a three-byte preamble followed by a status byte that encodes the field, the blanking state and whether the sequence opens or closes the line. A qualifier output marks every meaningful byte. Cycles that carry nothing output a zero filler byte with the qualifier inactive. A receiver stores only the qualified bytes and advances its write pointer only on them.

An external ready input lets a downstream consumer hold the stream. While ready is low the block starts no new pixel and no new reference sequence. A sequence that has already begun still runs to its end. Incoming beats wait in a small skid buffer. The input-side valid/ready handshake pushes back on the pixel source once that buffer is full, so the consumer receives pixels in bursts without any loss or duplication. Configuration inputs suppress the reference sequences, select the MSB of the status byte and set the polarity of the qualifier and of the two reference outputs. Those outputs act either as level gates or as single-cycle trigger pulses.

Top module: `vid_stream_fmt`

## Requirements
- R1: With reference sequences enabled, the stream carries the qualified bytes FFh, 00h, 00h and then a start status byte just before the first pixel of a line. After the last pixel of a line it carries FFh, 00h, 00h and then an end status byte.
- R2: The status byte is {MSB, F, V, H, P[3:0]}, where F is the field, V is vertical blanking and H is 0 for the start sequence and 1 for the end sequence. With MSB=0 the eight values are 0Eh, 13h, 25h, 38h for field 0 and 49h, 54h, 62h, 7Fh for field 1, listed in the order (V,H) = 00, 01, 10, 11.
- R3: For a start sequence, V is the inverse of the line's vertical-active flag. For an end sequence, V is 1 when the line is a blanking line or is marked as the last active line.
- R4: The status byte MSB is taken from cfg_msb. With MSB=1 the values are 80h, 9Dh, ABh, B6h for field 0 and C7h, DAh, ECh, F1h for field 1, in the same order.
- R5: On every cycle where out_dq is inactive, out_data is 00h.
- R6: With cfg_codes_en=0 no reference sequence is emitted, and only the pixel bytes appear as qualified data, in order.
- R7: While ext_rdy is low, no new pixel or sequence is started and the qualifier is inactive. A sequence whose FFh has already been emitted still completes its remaining three bytes.
- R8: in_ready goes low once the two-entry skid buffer holds two beats. Every accepted pixel appears exactly once, in order.
- R9: In gate mode (cfg_trig=0), out_hgate and out_vgate carry the horizontal-active and vertical-active flags of the most recently emitted pixel, aligned with that pixel's output cycle.
- R10: In trigger mode (cfg_trig=1), a reference output is active for exactly one cycle when its flag rises from one emitted pixel to the next.
- R11: Setting a polarity bit to 1 makes the matching output active-low. A polarity bit of 0 gives active-high.
- R12: After reset, out_data is 00h, the qualifier and both reference outputs are inactive, and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_codes_en | input | 1 | 1 inserts reference sequences |
| cfg_msb | input | 1 | MSB of the status byte |
| cfg_trig | input | 1 | 1 selects trigger pulses instead of gates |
| cfg_pol_dq | input | 1 | Qualifier polarity, 1 = active-low |
| cfg_pol_hg | input | 1 | Horizontal reference polarity, 1 = active-low |
| cfg_pol_vg | input | 1 | Vertical reference polarity, 1 = active-low |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| in_pix | input | 8 | Pixel byte |
| in_field | input | 1 | Field identifier |
| in_hact | input | 1 | Horizontal-active flag |
| in_vact | input | 1 | Vertical-active flag |
| in_sol | input | 1 | First pixel of a line |
| in_eol | input | 1 | Last pixel of a line |
| in_lastln | input | 1 | Line is the last active line |
| ext_rdy | input | 1 | Downstream ready; low holds output |
| out_data | output | 8 | Output byte stream |
| out_dq | output | 1 | Data qualifier |
| out_hgate | output | 1 | Horizontal gate or trigger |
| out_vgate | output | 1 | Vertical gate or trigger |

## Verification
The assertions assume that the polarity and mode configuration changes only during reset or while the stream is idle, and that every line is opened by a beat marked first-pixel and closed by one marked last-pixel. The bench sets each configuration before it sends a line and changes polarity only while reset is held. Every line it sends is a complete start/end pair. Stalls are applied both between sequences and immediately after a preamble has begun, so the no-interruption rule is exercised under the same assumptions the properties rely on.

// File: rtl/vsf_pkg.sv
package vsf_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] PRE_HI = 8'hFF;
  localparam logic [BYTE_W-1:0] FILL   = 8'h00;

  typedef struct packed {
    logic [BYTE_W-1:0] pix;
    logic              fld;
    logic              hon;
    logic              von;
    logic              sol;
    logic              eol;
    logic              lastln;
  } beat_t;

  typedef enum logic [1:0] {SQ_IDLE, SQ_Z1, SQ_Z2, SQ_CODE} seq_st_t;

  // status byte: {msb, field, vblank, end-flag, protection nibble}
  function automatic logic [BYTE_W-1:0] trc_code(input logic msb, input logic f,
                                                 input logic v, input logic h);
    logic [3:0] p;
    case ({msb, f, v, h})
      4'b0000: p = 4'hE;
      4'b0001: p = 4'h3;
      4'b0010: p = 4'h5;
      4'b0011: p = 4'h8;
      4'b0100: p = 4'h9;
      4'b0101: p = 4'h4;
      4'b0110: p = 4'h2;
      4'b0111: p = 4'hF;
      4'b1000: p = 4'h0;
      4'b1001: p = 4'hD;
      4'b1010: p = 4'hB;
      4'b1011: p = 4'h6;
      4'b1100: p = 4'h7;
      4'b1101: p = 4'hA;
      4'b1110: p = 4'hC;
      default: p = 4'h1;
    endcase
    return {msb, f, v, h, p};
  endfunction
endpackage

// File: rtl/vsf_skid.sv
module vsf_skid
  import vsf_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  wr_valid,
  output logic  wr_ready,
  input  beat_t wr_data,
  output logic  rd_valid,
  output beat_t rd_data,
  input  logic  rd_pop
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  beat_t          mem [DEPTH];
  logic [PW-1:0]  wp, rp;
  logic [CW-1:0]  cnt;
  logic           wr_fire, rd_fire;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign wr_ready = (cnt != CW'(DEPTH));
  assign rd_valid = (cnt != '0);
  assign rd_data  = mem[rp];
  assign wr_fire  = wr_valid & wr_ready;
  assign rd_fire  = rd_pop & rd_valid;

  always_ff @(posedge clk) begin
    if (wr_fire) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (wr_fire) wp <= nxt(wp);
      if (rd_fire) rp <= nxt(rp);
      case ({wr_fire, rd_fire})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/vsf_seq.sv
module vsf_seq
  import vsf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              codes_en,
  input  logic              msb,
  input  logic              pol_q,
  input  logic              ext_rdy,
  input  logic              head_valid,
  input  beat_t             head,
  output logic              pop,
  output logic [BYTE_W-1:0] out_byte,
  output logic              out_q,
  output logic              pix_fire,
  output logic              pix_h,
  output logic              pix_v,
  output seq_st_t           st
);
  logic [BYTE_W-1:0] code_r, eav_code;
  logic              sav_done, eav_pend;
  logic              start_eav, can_head, start_sav;

  always_comb begin
    start_eav = (st == SQ_IDLE) && eav_pend && codes_en && ext_rdy;
    can_head  = (st == SQ_IDLE) && !eav_pend && head_valid && ext_rdy;
    start_sav = can_head && codes_en && head.sol && !sav_done;
    pix_fire  = can_head && !start_sav;
    pop       = pix_fire;
    pix_h     = head.hon;
    pix_v     = head.von;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= SQ_IDLE;
      out_byte <= FILL;
      out_q    <= pol_q;
      code_r   <= '0;
      eav_code <= '0;
      sav_done <= 1'b0;
      eav_pend <= 1'b0;
    end else begin
      out_byte <= FILL;
      out_q    <= pol_q;
      case (st)
        SQ_Z1: begin
          out_q <= ~pol_q;
          st    <= SQ_Z2;
        end
        SQ_Z2: begin
          out_q <= ~pol_q;
          st    <= SQ_CODE;
        end
        SQ_CODE: begin
          out_byte <= code_r;
          out_q    <= ~pol_q;
          st       <= SQ_IDLE;
        end
        default: begin
          if (start_eav) begin
            out_byte <= PRE_HI;
            out_q    <= ~pol_q;
            code_r   <= eav_code;
            eav_pend <= 1'b0;
            st       <= SQ_Z1;
          end else if (start_sav) begin
            out_byte <= PRE_HI;
            out_q    <= ~pol_q;
            code_r   <= trc_code(msb, head.fld, ~head.von, 1'b0);
            sav_done <= 1'b1;
            st       <= SQ_Z1;
          end else if (pix_fire) begin
            out_byte <= head.pix;
            out_q    <= ~pol_q;
            sav_done <= 1'b0;
            if (codes_en && head.eol) begin
              eav_pend <= 1'b1;
              eav_code <= trc_code(msb, head.fld, ~head.von | head.lastln, 1'b1);
            end
          end
        end
      endcase
      if (!codes_en) eav_pend <= 1'b0;
    end
  end
endmodule

// File: rtl/vsf_refout.sv
module vsf_refout #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           trig,
  input  logic [NCH-1:0] pol,
  input  logic           fire,
  input  logic [NCH-1:0] lvl,
  output logic [NCH-1:0] ref_out
);
  for (genvar gi = 0; gi < NCH; gi++) begin : g_ch
    logic st_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        st_q        <= 1'b0;
        ref_out[gi] <= pol[gi];
      end else begin
        if (fire) st_q <= lvl[gi];
        if (trig) ref_out[gi] <= (fire & lvl[gi] & ~st_q) ^ pol[gi];
        else      ref_out[gi] <= (fire ? lvl[gi] : st_q) ^ pol[gi];
      end
    end
  end
endmodule

// File: rtl/vid_stream_fmt.sv
module vid_stream_fmt
  import vsf_pkg::*;
#(
  parameter int SKID_DEPTH = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_codes_en,
  input  logic       cfg_msb,
  input  logic       cfg_trig,
  input  logic       cfg_pol_dq,
  input  logic       cfg_pol_hg,
  input  logic       cfg_pol_vg,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_pix,
  input  logic       in_field,
  input  logic       in_hact,
  input  logic       in_vact,
  input  logic       in_sol,
  input  logic       in_eol,
  input  logic       in_lastln,
  input  logic       ext_rdy,
  output logic [7:0] out_data,
  output logic       out_dq,
  output logic       out_hgate,
  output logic       out_vgate
);
  beat_t   wr_beat, head;
  logic    head_valid, pop, fire, ph, pv;
  logic [1:0] refs;
  seq_st_t seq_st;

  assign wr_beat = '{pix: in_pix, fld: in_field, hon: in_hact, von: in_vact,
                     sol: in_sol, eol: in_eol, lastln: in_lastln};

  vsf_skid #(.DEPTH(SKID_DEPTH)) u_skid (
    .clk(clk), .rst(rst),
    .wr_valid(in_valid), .wr_ready(in_ready), .wr_data(wr_beat),
    .rd_valid(head_valid), .rd_data(head), .rd_pop(pop)
  );

  vsf_seq u_seq (
    .clk(clk), .rst(rst),
    .codes_en(cfg_codes_en), .msb(cfg_msb), .pol_q(cfg_pol_dq), .ext_rdy(ext_rdy),
    .head_valid(head_valid), .head(head), .pop(pop),
    .out_byte(out_data), .out_q(out_dq),
    .pix_fire(fire), .pix_h(ph), .pix_v(pv), .st(seq_st)
  );

  vsf_refout #(.NCH(2)) u_ref (
    .clk(clk), .rst(rst), .trig(cfg_trig),
    .pol({cfg_pol_vg, cfg_pol_hg}), .fire(fire), .lvl({pv, ph}),
    .ref_out(refs)
  );

  assign out_hgate = refs[0];
  assign out_vgate = refs[1];
endmodule

// File: rtl/vsf_chk.sv
module vsf_chk
  import vsf_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       ext_rdy,
  input logic       cfg_pol_dq,
  input logic       cfg_pol_hg,
  input logic       cfg_trig,
  input logic [7:0] out_data,
  input logic       out_dq,
  input logic       out_hgate,
  input seq_st_t    st
);
  // R1: the first preamble byte is on the output when the sequencer enters Z1
  a_r1_preamble_head: assert property (@(posedge clk) disable iff (rst)
    (st == SQ_Z1) |-> (out_data == PRE_HI && out_dq != cfg_pol_dq));

  // R7: a started sequence runs through without a gap
  a_r7_seq_z1: assert property (@(posedge clk) disable iff (rst)
    (st == SQ_Z1) |=> (st == SQ_Z2));
  a_r7_seq_z2: assert property (@(posedge clk) disable iff (rst)
    (st == SQ_Z2) |=> (st == SQ_CODE));

  // R7: stalled while idle gives no qualified byte next cycle
  a_r7_stall_idle: assert property (@(posedge clk) disable iff (rst)
    (!ext_rdy && st == SQ_IDLE) |=> (out_dq == cfg_pol_dq));

  // R5: unqualified cycles carry the filler byte
  a_r5_filler: assert property (@(posedge clk) disable iff (rst)
    (out_dq == cfg_pol_dq) |-> (out_data == FILL));

  // R10: a trigger pulse lasts a single cycle
  a_r10_one_cycle: assert property (@(posedge clk) disable iff (rst)
    (cfg_trig && out_hgate != cfg_pol_hg) |=> (out_hgate == cfg_pol_hg));
endmodule

bind vid_stream_fmt vsf_chk u_chk (
  .clk(clk), .rst(rst), .ext_rdy(ext_rdy),
  .cfg_pol_dq(cfg_pol_dq), .cfg_pol_hg(cfg_pol_hg), .cfg_trig(cfg_trig),
  .out_data(out_data), .out_dq(out_dq), .out_hgate(out_hgate), .st(seq_st)
);

// File: tb/sim_vid_stream_fmt.sv
`timescale 1ns/1ps
module sim_vid_stream_fmt;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1;
  logic cfg_codes_en = 1'b1, cfg_msb = 1'b0, cfg_trig = 1'b0;
  logic cfg_pol_dq = 1'b0, cfg_pol_hg = 1'b0, cfg_pol_vg = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [7:0] in_pix = '0;
  logic in_field = 0, in_hact = 0, in_vact = 0, in_sol = 0, in_eol = 0, in_lastln = 0;
  logic ext_rdy = 1'b1;
  logic [7:0] out_data;
  logic out_dq, out_hgate, out_vgate;

  vid_stream_fmt #(.SKID_DEPTH(2)) u0 (
    .clk(clk), .rst(rst), .cfg_codes_en(cfg_codes_en), .cfg_msb(cfg_msb),
    .cfg_trig(cfg_trig), .cfg_pol_dq(cfg_pol_dq), .cfg_pol_hg(cfg_pol_hg),
    .cfg_pol_vg(cfg_pol_vg), .in_valid(in_valid), .in_ready(in_ready),
    .in_pix(in_pix), .in_field(in_field), .in_hact(in_hact), .in_vact(in_vact),
    .in_sol(in_sol), .in_eol(in_eol), .in_lastln(in_lastln), .ext_rdy(ext_rdy),
    .out_data(out_data), .out_dq(out_dq), .out_hgate(out_hgate), .out_vgate(out_vgate)
  );

  int checks = 0, errors = 0;
  logic [7:0] cap [1024];
  int cap_n = 0, bad_fill = 0, hg_cnt = 0;
  logic [7:0] exb [16];

  // capture of qualified bytes, filler watch, active-cycle count of the horizontal output
  always @(negedge clk) begin
    if (!rst) begin
      if (out_dq ^ cfg_pol_dq) begin
        if (cap_n < 1024) cap[cap_n] <= out_data;
        cap_n <= cap_n + 1;
      end else if (out_data != 8'h00) begin
        bad_fill <= bad_fill + 1;
      end
      if (out_hgate ^ cfg_pol_hg) hg_cnt <= hg_cnt + 1;
    end
  end

  // rows: {msb, field, vblank, lastln, pix, start code, end code}
  localparam logic [27:0] VEC [10] = '{
    {4'b0000, 8'h10, 8'h0E, 8'h13},
    {4'b0010, 8'h20, 8'h25, 8'h38},
    {4'b0100, 8'h30, 8'h49, 8'h54},
    {4'b0110, 8'h40, 8'h62, 8'h7F},
    {4'b1000, 8'h50, 8'h80, 8'h9D},
    {4'b1010, 8'h60, 8'hAB, 8'hB6},
    {4'b1100, 8'h70, 8'hC7, 8'hDA},
    {4'b1110, 8'h88, 8'hEC, 8'hF1},
    {4'b0001, 8'h99, 8'h0E, 8'h38},
    {4'b1101, 8'hA5, 8'hC7, 8'hF1}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] d, input logic f, input logic h, input logic v,
                      input logic s, input logic e, input logic l);
    @(negedge clk);
    in_valid = 1'b1; in_pix = d; in_field = f; in_hact = h; in_vact = v;
    in_sol = s; in_eol = e; in_lastln = l;
    while (!in_ready) @(negedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic cmp(input int base, input int n, input string req);
    int got;
    int bad;
    got = cap_n - base;
    bad = -1;
    for (int k = 0; k < n; k++)
      if (bad < 0 && k < got && cap[base + k] !== exb[k]) bad = k;
    if (got != n) chk(1'b0, {req, " byte count"}, got, n);
    else if (bad >= 0) chk(1'b0, {req, " stream byte"}, cap[base + bad], exb[bad]);
    else chk(1'b1, req, 0, 0);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks + 1, errors + 1);
    $finish;
  end

  initial begin
    int base;
    logic [27:0] row;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk(out_data == 8'h00, "R12 out_data", out_data, 0);
    chk(out_dq == 1'b0, "R12 out_dq", out_dq, 0);
    chk(out_hgate == 1'b0, "R12 out_hgate", out_hgate, 0);
    chk(out_vgate == 1'b0, "R12 out_vgate", out_vgate, 0);
    chk(in_ready == 1'b1, "R12 in_ready", in_ready, 1);

    // table walk: R1 R2 R3 R4
    for (int i = 0; i < 10; i++) begin
      row = VEC[i];
      cfg_msb = row[27];
      base = cap_n;
      send(row[23:16], row[26], 1'b1, ~row[25], 1'b1, 1'b0, row[24]);
      send(row[23:16] + 8'd1, row[26], 1'b1, ~row[25], 1'b0, 1'b1, row[24]);
      idle();
      repeat (16) @(negedge clk);
      exb[0] = 8'hFF; exb[1] = 8'h00; exb[2] = 8'h00; exb[3] = row[15:8];
      exb[4] = row[23:16]; exb[5] = row[23:16] + 8'd1;
      exb[6] = 8'hFF; exb[7] = 8'h00; exb[8] = 8'h00; exb[9] = row[7:0];
      cmp(base, 10, "R1 R2 R3 R4 line");
    end
    cfg_msb = 1'b0;

    // R7 R8: stall with buffer filling
    ext_rdy = 1'b0;
    base = cap_n;
    send(8'hA1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    send(8'hA2, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    in_pix = 8'hA3; in_sol = 1'b0; in_eol = 1'b1;
    chk(in_ready == 1'b0, "R8 backpressure when full", in_ready, 0);
    repeat (5) @(negedge clk);
    chk(cap_n == base, "R7 no output while stalled", cap_n - base, 0);
    chk(in_ready == 1'b0, "R8 held while stalled", in_ready, 0);
    ext_rdy = 1'b1;
    while (!in_ready) @(negedge clk);
    idle();
    repeat (20) @(negedge clk);
    exb[0] = 8'hFF; exb[1] = 8'h00; exb[2] = 8'h00; exb[3] = 8'h0E;
    exb[4] = 8'hA1; exb[5] = 8'hA2; exb[6] = 8'hA3;
    exb[7] = 8'hFF; exb[8] = 8'h00; exb[9] = 8'h00; exb[10] = 8'h13;
    cmp(base, 11, "R8 no loss after stall");

    // R7: stall arriving right after the preamble begins
    base = cap_n;
    send(8'hB1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    idle();
    for (int k = 0; k < 20; k++) begin
      if ((out_dq ^ cfg_pol_dq) && out_data == 8'hFF) break;
      @(negedge clk);
    end
    ext_rdy = 1'b0;
    repeat (6) @(negedge clk);
    chk(cap_n - base == 4, "R7 sequence completes under stall", cap_n - base, 4);
    send(8'hB2, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    ext_rdy = 1'b1;
    idle();
    repeat (20) @(negedge clk);
    exb[0] = 8'hFF; exb[1] = 8'h00; exb[2] = 8'h00; exb[3] = 8'h0E;
    exb[4] = 8'hB1; exb[5] = 8'hB2;
    exb[6] = 8'hFF; exb[7] = 8'h00; exb[8] = 8'h00; exb[9] = 8'h13;
    cmp(base, 10, "R7 stream after mid-sequence stall");

    // R6: codes suppressed
    cfg_codes_en = 1'b0;
    base = cap_n;
    send(8'hC1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    send(8'hC2, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    idle();
    repeat (10) @(negedge clk);
    exb[0] = 8'hC1; exb[1] = 8'hC2;
    cmp(base, 2, "R6 pixels only");

    // R9: gate levels follow the last emitted pixel
    send(8'h11, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
    idle();
    repeat (4) @(negedge clk);
    chk(out_hgate == 1'b1, "R9 hgate high", out_hgate, 1);
    chk(out_vgate == 1'b0, "R9 vgate low", out_vgate, 0);
    send(8'h12, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    idle();
    repeat (4) @(negedge clk);
    chk(out_hgate == 1'b0, "R9 hgate low", out_hgate, 0);
    chk(out_vgate == 1'b1, "R9 vgate high", out_vgate, 1);

    // R10: trigger pulse
    cfg_trig = 1'b1;
    repeat (2) @(negedge clk);
    base = hg_cnt;
    send(8'h21, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    send(8'h22, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    idle();
    repeat (8) @(negedge clk);
    chk(hg_cnt - base == 1, "R10 single pulse", hg_cnt - base, 1);
    cfg_trig = 1'b0;

    // R11: polarity inversion, applied under reset
    rst = 1'b1;
    cfg_pol_dq = 1'b1; cfg_pol_hg = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(out_dq == 1'b1, "R11 qualifier idle high", out_dq, 1);
    chk(out_hgate == 1'b1, "R11 hgate idle high", out_hgate, 1);
    base = cap_n;
    send(8'h5A, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
    idle();
    repeat (6) @(negedge clk);
    chk(out_hgate == 1'b0, "R11 hgate active low", out_hgate, 0);
    exb[0] = 8'h5A;
    cmp(base, 1, "R11 active-low qualified pixel");

    chk(bad_fill == 0, "R5 filler is 00h", bad_fill, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule